// File: doc/BRIEF.md
# Parallel Bayer Pixel Capture Receiver

This block sits at the pins of a CMOS image sensor that drives a pixel clock, a 12-bit pixel bus, a frame-valid strobe and a line-valid strobe. All inputs are sampled on the falling edge of the pixel clock. Only words present while both strobes are high are kept. Each kept word is handed downstream with its column index, its row index and a two-bit Bayer color tag. The tag tells apart the green pixels on red rows from the green pixels on blue rows. Two static mirror inputs flip the color phase along a row and between rows, to match a sensor that reads out mirrored.

Frame and line timing is reported on single-cycle pulses: start of frame, end of line and end of frame. End of frame also carries the number of lines counted in the frame. Three sticky error bits record the following faults:
- a line strobe seen outside a frame;
- a line whose length differs from the first line of its frame;
- a pixel lost to back-pressure.

The pixel output is a valid/ready stream with a one-entry output register. A word that has not been taken stays on the outputs, unchanged, until ready is seen high on a falling edge. The sensor cannot be stalled. If a new pixel is accepted while the output register still holds an untaken word, the new pixel is discarded and the overrun error is set. A consumer that wants every pixel must therefore take a word within one pixel-clock period of it appearing.

Top module: `bayer_capture_rx`

## Requirements
- R1: Bus and strobes are sampled on the falling edge of `pix_clk`. A word sampled on falling edge k appears on `m_data`, with `m_valid` high, after falling edge k+1. Bit 11 of the bus is the MSB.
- R2: A word is emitted only if both frame-valid and line-valid were high when it was sampled. Words are emitted in arrival order, one output per such word.
- R3: `m_col` is 0 for the first word after each rising edge of line-valid and rises by 1 for each later word of that line.
- R4: `m_row` is 0 for lines of a frame before the first line end. It rises by 1 after each falling edge of line-valid that happens while frame-valid was high.
- R5: `m_color` = {row parity XOR vmirror, column parity XOR hmirror}, encoded Gr=0, R=1, B=2, Gb=3. With no mirroring, even rows therefore give Gr,R,Gr,R and odd rows give B,Gb,B,Gb.
- R6: `hmirror` swaps the starting color within each row. `vmirror` swaps the row pattern, so that row 0 gives B,Gb.
- R7: `sof` pulses high for one cycle, one falling edge after frame-valid is sampled rising.
- R8: `eol` pulses high for one cycle, one falling edge after line-valid is sampled falling while frame-valid had been high.
- R9: `eof` pulses high for one cycle, one falling edge after frame-valid is sampled falling. At the same moment `eof_lines` takes the number of line ends counted in that frame and holds it until the next end of frame.
- R10: `err[0]` is set, and stays set until reset, when line-valid is sampled high while frame-valid is low. Such a word is not emitted.
- R11: `err[1]` is set, and stays set until reset, when a line after the first line of a frame has a different number of words from the first line.
- R12: While `m_valid` is high and `m_ready` low, the outputs hold. A newly accepted word arriving at that time is dropped and sets `err[2]`, which stays set until reset.
- R13: After reset, `m_valid`, `sof`, `eol`, `eof`, `eof_lines` and `err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Sensor pixel clock; the block works on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hmirror | input | 1 | Horizontal mirror: swaps color phase along a row |
| vmirror | input | 1 | Vertical mirror: swaps row color pattern |
| pix_data | input | DATA_W (12) | Pixel bus from the sensor |
| fv_in | input | 1 | Frame-valid strobe |
| lv_in | input | 1 | Line-valid strobe |
| m_ready | input | 1 | Downstream ready |
| m_valid | output | 1 | Output pixel valid |
| m_data | output | DATA_W (12) | Output pixel value |
| m_col | output | COL_W (12) | Column index of the output pixel |
| m_row | output | ROW_W (12) | Row index of the output pixel |
| m_color | output | 2 | Bayer tag: 0 Gr, 1 R, 2 B, 3 Gb |
| sof | output | 1 | Start-of-frame pulse |
| eol | output | 1 | End-of-line pulse |
| eof | output | 1 | End-of-frame pulse |
| eof_lines | output | ROW_W (12) | Lines counted in the frame just ended |
| err | output | 3 | Sticky errors: bit 0 stray line, bit 1 length mismatch, bit 2 overrun |

## Verification
The hardest state to reach is an overrun: a word still held on the outputs at the moment the next word is accepted. With ready kept high this never happens. The bench therefore runs one frame with ready held low on every third cycle, which leaves words held across line data.

Line-length mismatch and a stray line strobe outside a frame are brought about by dedicated frames near the end of the run. One line in a frame is cut short, and line-valid is pulsed while frame-valid is low. These come last because the error bits are sticky.

Every cycle is compared against a behavioural model, so the mirror combinations and the line-count value carried with end of frame are checked on every frame.

// File: rtl/bc_pkg.sv
package bc_pkg;

  typedef enum logic [1:0] {
    CLR_GR = 2'd0,
    CLR_R  = 2'd1,
    CLR_B  = 2'd2,
    CLR_GB = 2'd3
  } bayer_clr_e;

  localparam int ERR_W       = 3;
  localparam int ERR_STRAY   = 0;
  localparam int ERR_LEN     = 1;
  localparam int ERR_OVERRUN = 2;

  typedef struct packed {
    logic lv;        // line-valid as sampled
    logic act;       // word to keep: both strobes high
    logic stray;     // line strobe outside a frame
    logic lv_rise;   // first word of a line
    logic line_end;  // line closed while frame was open
    logic fv_rise;   // frame opens
    logic fv_fall;   // frame closes
  } strobe_ev_t;

endpackage

// File: rtl/bc_sampler.sv
module bc_sampler
  import bc_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              fv,
  input  logic              lv,
  output logic [DATA_W-1:0] s_dat,
  output strobe_ev_t        ev
);

  logic s_fv, s_lv;
  logic p_fv, p_lv;

  // Falling-edge capture of bus and strobes, plus one more stage for edges
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_dat <= '0;
      s_fv  <= 1'b0;
      s_lv  <= 1'b0;
      p_fv  <= 1'b0;
      p_lv  <= 1'b0;
    end else begin
      s_dat <= din;
      s_fv  <= fv;
      s_lv  <= lv;
      p_fv  <= s_fv;
      p_lv  <= s_lv;
    end
  end

  always_comb begin
    ev.lv       = s_lv;
    ev.act      = s_lv & s_fv;
    ev.stray    = s_lv & ~s_fv;
    ev.lv_rise  = s_lv & ~p_lv;
    ev.line_end = ~s_lv & p_lv & p_fv;
    ev.fv_rise  = s_fv & ~p_fv;
    ev.fv_fall  = ~s_fv & p_fv;
  end

endmodule

// File: rtl/bc_position.sv
module bc_position #(
  parameter int COL_W = 12,
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lv,
  input  logic             lv_rise,
  input  logic             line_end,
  input  logic             fv_rise,
  output logic [COL_W-1:0] pix_col,
  output logic [ROW_W-1:0] pix_row,
  output logic [ROW_W-1:0] lines_done,
  output logic             len_bad
);

  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] ref_len_q;
  logic             first_line;

  assign pix_col    = lv_rise ? '0 : col_q;
  assign pix_row    = fv_rise ? '0 : row_q;
  assign first_line = (row_q == '0);
  assign len_bad    = line_end & ~first_line & (col_q != ref_len_q);
  assign lines_done = row_q + ROW_W'(line_end);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q     <= '0;
      row_q     <= '0;
      ref_len_q <= '0;
    end else begin
      if (lv) col_q <= pix_col + 1'b1;
      if (fv_rise) begin
        row_q <= '0;
      end else if (line_end) begin
        row_q <= row_q + 1'b1;
        if (first_line) ref_len_q <= col_q;
      end
    end
  end

endmodule

// File: rtl/bc_tagger.sv
module bc_tagger
  import bc_pkg::*;
(
  input  logic       col_lsb,
  input  logic       row_lsb,
  input  logic       hmirror,
  input  logic       vmirror,
  output bayer_clr_e color
);

  logic row_ph, col_ph;

  assign row_ph = row_lsb ^ vmirror;
  assign col_ph = col_lsb ^ hmirror;

  always_comb begin
    unique case ({row_ph, col_ph})
      2'b00:   color = CLR_GR;
      2'b01:   color = CLR_R;
      2'b10:   color = CLR_B;
      default: color = CLR_GB;
    endcase
  end

endmodule

// File: rtl/bc_out_stage.sv
module bc_out_stage
  import bc_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int COL_W  = 12,
  parameter int ROW_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [DATA_W-1:0] in_data,
  input  logic [COL_W-1:0]  in_col,
  input  logic [ROW_W-1:0]  in_row,
  input  bayer_clr_e        in_color,
  input  logic              m_ready,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic [COL_W-1:0]  m_col,
  output logic [ROW_W-1:0]  m_row,
  output bayer_clr_e        m_color,
  output logic              drop
);

  logic stalled;

  assign stalled = m_valid & ~m_ready;
  assign drop    = acc & stalled;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_col   <= '0;
      m_row   <= '0;
      m_color <= CLR_GR;
    end else if (acc && !stalled) begin
      m_valid <= 1'b1;
      m_data  <= in_data;
      m_col   <= in_col;
      m_row   <= in_row;
      m_color <= in_color;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/bayer_capture_rx.sv
module bayer_capture_rx
  import bc_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int COL_W  = 12,
  parameter int ROW_W  = 12
) (
  input  logic              pix_clk,
  input  logic              rst_n,
  input  logic              hmirror,
  input  logic              vmirror,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              fv_in,
  input  logic              lv_in,
  input  logic              m_ready,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic [COL_W-1:0]  m_col,
  output logic [ROW_W-1:0]  m_row,
  output logic [1:0]        m_color,
  output logic              sof,
  output logic              eol,
  output logic              eof,
  output logic [ROW_W-1:0]  eof_lines,
  output logic [ERR_W-1:0]  err
);

  strobe_ev_t        ev;
  logic [DATA_W-1:0] s_dat;
  logic [COL_W-1:0]  pix_col;
  logic [ROW_W-1:0]  pix_row;
  logic [ROW_W-1:0]  lines_done;
  logic              len_bad;
  logic              drop;
  bayer_clr_e        tag;
  bayer_clr_e        out_tag;
  logic [ERR_W-1:0]  err_set;

  bc_sampler #(.DATA_W(DATA_W)) u_smp (
    .clk   (pix_clk),
    .rst_n (rst_n),
    .din   (pix_data),
    .fv    (fv_in),
    .lv    (lv_in),
    .s_dat (s_dat),
    .ev    (ev)
  );

  bc_position #(.COL_W(COL_W), .ROW_W(ROW_W)) u_pos (
    .clk        (pix_clk),
    .rst_n      (rst_n),
    .lv         (ev.lv),
    .lv_rise    (ev.lv_rise),
    .line_end   (ev.line_end),
    .fv_rise    (ev.fv_rise),
    .pix_col    (pix_col),
    .pix_row    (pix_row),
    .lines_done (lines_done),
    .len_bad    (len_bad)
  );

  bc_tagger u_tag (
    .col_lsb (pix_col[0]),
    .row_lsb (pix_row[0]),
    .hmirror (hmirror),
    .vmirror (vmirror),
    .color   (tag)
  );

  bc_out_stage #(.DATA_W(DATA_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_out (
    .clk      (pix_clk),
    .rst_n    (rst_n),
    .acc      (ev.act),
    .in_data  (s_dat),
    .in_col   (pix_col),
    .in_row   (pix_row),
    .in_color (tag),
    .m_ready  (m_ready),
    .m_valid  (m_valid),
    .m_data   (m_data),
    .m_col    (m_col),
    .m_row    (m_row),
    .m_color  (out_tag),
    .drop     (drop)
  );

  assign m_color = out_tag;

  always_comb begin
    err_set              = '0;
    err_set[ERR_STRAY]   = ev.stray;
    err_set[ERR_LEN]     = len_bad;
    err_set[ERR_OVERRUN] = drop;
  end

  always_ff @(negedge pix_clk or negedge rst_n) begin
    if (!rst_n) begin
      sof       <= 1'b0;
      eol       <= 1'b0;
      eof       <= 1'b0;
      eof_lines <= '0;
      err       <= '0;
    end else begin
      sof <= ev.fv_rise;
      eol <= ev.line_end;
      eof <= ev.fv_fall;
      if (ev.fv_fall) eof_lines <= lines_done;
      err <= err | err_set;
    end
  end

endmodule

// File: rtl/bc_capture_chk.sv
module bc_capture_chk #(
  parameter int DATA_W = 12,
  parameter int COL_W  = 12,
  parameter int ROW_W  = 12
) (
  input logic              pix_clk,
  input logic              rst_n,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic [COL_W-1:0]  m_col,
  input logic [ROW_W-1:0]  m_row,
  input logic              sof,
  input logic              eof,
  input logic [2:0]        err
);

  // R12: an untaken word stays put
  p_hold_word_r12: assert property (@(negedge pix_clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_col) && $stable(m_row));

  // R10: stray-line error is sticky
  p_stray_sticky_r10: assert property (@(negedge pix_clk) disable iff (!rst_n)
    err[0] |=> err[0]);

  // R11: length error is sticky
  p_len_sticky_r11: assert property (@(negedge pix_clk) disable iff (!rst_n)
    err[1] |=> err[1]);

  // R12: overrun error is sticky
  p_overrun_sticky_r12: assert property (@(negedge pix_clk) disable iff (!rst_n)
    err[2] |=> err[2]);

  // R7: start of frame is a single-cycle pulse
  p_sof_pulse_r7: assert property (@(negedge pix_clk) disable iff (!rst_n)
    sof |=> !sof);

  // R9: end of frame is a single-cycle pulse
  p_eof_pulse_r9: assert property (@(negedge pix_clk) disable iff (!rst_n)
    eof |=> !eof);

endmodule

bind bayer_capture_rx bc_capture_chk #(.DATA_W(DATA_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
  .pix_clk (pix_clk),
  .rst_n   (rst_n),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_data  (m_data),
  .m_col   (m_col),
  .m_row   (m_row),
  .sof     (sof),
  .eof     (eof),
  .err     (err)
);

// File: tb/bayer_capture_rx_tb.sv
`timescale 1ns/1ps
module bayer_capture_rx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hmirror = 1'b0, vmirror = 1'b0;
  logic [11:0] pix_data = '0;
  logic        fv_in = 1'b0, lv_in = 1'b0;
  logic        m_ready = 1'b1;
  logic        m_valid;
  logic [11:0] m_data, m_col, m_row, eof_lines;
  logic [1:0]  m_color;
  logic        sof, eol, eof;
  logic [2:0]  err;

  int nchk = 0, nerr = 0, cyc = 0;
  int rdy_mode = 0;
  int dval = 100;
  bit done = 0;

  always #5 clk = ~clk;

  bayer_capture_rx u_dut (
    .pix_clk(clk), .rst_n(rst_n), .hmirror(hmirror), .vmirror(vmirror),
    .pix_data(pix_data), .fv_in(fv_in), .lv_in(lv_in), .m_ready(m_ready),
    .m_valid(m_valid), .m_data(m_data), .m_col(m_col), .m_row(m_row),
    .m_color(m_color), .sof(sof), .eol(eol), .eof(eof),
    .eof_lines(eof_lines), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // History of the last two sampled strobe values, kept as integers
  int hist_fv[2], hist_lv[2], hist_d;
  int line_words, cur_line, first_len;
  int e_valid, e_data, e_col, e_row, e_color;
  int e_sof, e_eol, e_eof, e_lines;
  int e_err[3];

  always @(negedge clk) begin
    if (!rst_n) begin
      hist_fv = '{0, 0}; hist_lv = '{0, 0}; hist_d = 0;
      line_words = 0; cur_line = 0; first_len = 0;
      e_valid = 0; e_data = 0; e_col = 0; e_row = 0; e_color = 0;
      e_sof = 0; e_eol = 0; e_eof = 0; e_lines = 0;
      e_err = '{0, 0, 0};
    end else begin
      int now_fv, now_lv, old_fv, old_lv, col, row;
      bit stalled, closing;
      now_fv = hist_fv[0]; now_lv = hist_lv[0];
      old_fv = hist_fv[1]; old_lv = hist_lv[1];
      stalled = (e_valid == 1) && !m_ready;
      col = (now_lv && !old_lv) ? 0 : line_words;
      row = (now_fv && !old_fv) ? 0 : cur_line;
      if (now_fv && now_lv) begin
        if (stalled) e_err[2] = 1;
        else begin
          e_valid = 1; e_data = hist_d; e_col = col; e_row = row;
          e_color = 2 * ((row % 2) ^ int'(vmirror)) + ((col % 2) ^ int'(hmirror));
        end
      end else if (!stalled) e_valid = 0;
      if (now_lv) line_words = col + 1;
      if (now_lv && !now_fv) e_err[0] = 1;
      e_sof = (now_fv && !old_fv);
      closing = (!now_lv && old_lv && old_fv);
      e_eol = closing;
      if (e_sof) cur_line = 0;
      if (closing) begin
        if (cur_line == 0) first_len = line_words;
        else if (line_words != first_len) e_err[1] = 1;
        cur_line++;
      end
      e_eof = (!now_fv && old_fv);
      if (e_eof) e_lines = cur_line;
      hist_fv[1] = now_fv; hist_lv[1] = now_lv;
      hist_fv[0] = int'(fv_in); hist_lv[0] = int'(lv_in); hist_d = int'(pix_data);
    end
  end

  // ---------------- comparison, away from the falling edge ----------------
  always @(posedge clk) begin
    cyc++;
    if (rdy_mode == 0) m_ready <= 1'b1;
    else m_ready <= (cyc % 3) != 0;
    if (!rst_n && cyc == 3) begin
      chk(m_valid == 0, "R13 m_valid after reset", int'(m_valid), 0);
      chk(err == 0, "R13 err after reset", int'(err), 0);
      chk(eof_lines == 0, "R13 eof_lines after reset", int'(eof_lines), 0);
    end
    if (cyc > 3 && !done) begin
      chk(int'(m_valid) == e_valid, "R2 valid", int'(m_valid), e_valid);
      if (e_valid == 1 && m_valid) begin
        chk(int'(m_data) == e_data, "R1 data", int'(m_data), e_data);
        chk(int'(m_col) == e_col, "R3 column", int'(m_col), e_col);
        chk(int'(m_row) == e_row, "R4 row", int'(m_row), e_row);
        chk(int'(m_color) == e_color, "R5 R6 color tag", int'(m_color), e_color);
      end
      chk(int'(sof) == e_sof, "R7 sof", int'(sof), e_sof);
      chk(int'(eol) == e_eol, "R8 eol", int'(eol), e_eol);
      chk(int'(eof) == e_eof, "R9 eof", int'(eof), e_eof);
      chk(int'(eof_lines) == e_lines, "R9 eof_lines", int'(eof_lines), e_lines);
      chk(int'(err[0]) == e_err[0], "R10 stray error", int'(err[0]), e_err[0]);
      chk(int'(err[1]) == e_err[1], "R11 length error", int'(err[1]), e_err[1]);
      chk(int'(err[2]) == e_err[2], "R12 overrun error", int'(err[2]), e_err[2]);
    end
    if (cyc > 100000 && !done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input bit f, input bit l);
    @(posedge clk);
    fv_in <= f; lv_in <= l;
    pix_data <= 12'(dval);
    dval = (dval * 7 + 13) % 4096;
  endtask

  task automatic frame(input int lines, input int len, input int short_line);
    step(1, 0); step(1, 0);
    for (int ln = 0; ln < lines; ln++) begin
      int n;
      n = (ln == short_line) ? len - 1 : len;
      for (int k = 0; k < n; k++) step(1, 1);
      step(1, 0); step(1, 0); step(1, 0);
    end
    step(0, 0); step(0, 0); step(0, 0); step(0, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    rst_n <= 1'b1;
    repeat (3) @(posedge clk);
    // R2 R3 R4 R5: plain frame
    frame(3, 6, -1);
    // R6: each mirror combination
    for (int m = 1; m < 4; m++) begin
      @(posedge clk);
      hmirror <= m[0]; vmirror <= m[1];
      frame(4, 5, -1);
    end
    @(posedge clk); hmirror <= 1'b0; vmirror <= 1'b0;
    // R9: single-line frame, and line-valid dropping with frame-valid
    frame(1, 8, -1);
    step(1, 0); step(1, 1); step(1, 1); step(1, 1); step(0, 0);
    step(0, 0); step(0, 0);
    // R11: one line cut short
    frame(4, 6, 2);
    frame(2, 4, -1);
    // R12: back-pressure causing drops
    rdy_mode = 1;
    frame(3, 7, -1);
    rdy_mode = 0;
    step(0, 0); step(0, 0);
    // R10: line strobe outside any frame
    step(0, 1); step(0, 1); step(0, 0); step(0, 0);
    frame(2, 3, -1);
    repeat (4) @(posedge clk);
    chk(err == 3'b111, "R10 R11 R12 final sticky error bits", int'(err), 7);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule